// File: doc/BRIEF.md
# Lookahead-Gated Multithread Issue Controller

This block decides, every clock cycle, which of many hardware threads may send one instruction into a long, non-bypassed pipeline. Each thread's next instruction carries a 3-bit independence count. The count says how many later instructions of the same thread do not depend on it. An idle thread that issues opens a window of that many extra issues. After the window is used up, the thread waits until the instruction that opened it reports completion. This lets a handful of threads keep a deep pipeline busy. Completion latency is free to vary, from a short arithmetic result to a memory access hundreds of cycles long.

The surrounding pipeline raises a per-thread "instruction ready" flag and presents the independence count of that instruction. The controller answers in the same cycle with a valid flag and the chosen thread number; the grant is taken as the issue. Completions return as a valid flag plus a thread number, at most one per cycle. Selection among eligible threads rotates, starting just after the thread that issued last.

Top module: `la_issue_ctrl`

## Requirements
- R1: After synchronous reset every thread is idle and eligible, and the rotation starts at thread 0 (with all threads ready the first grant goes to thread 0).
- R2: At most one thread is granted per cycle, and a grant names only a thread whose ready flag is set in that cycle.
- R3: Whenever some ready thread is eligible, a grant is made in that cycle.
- R4: Among eligible ready threads the grant goes to the first one found searching upward from the last granted thread number plus one, wrapping after the highest thread.
- R5: A grant to an idle thread makes that thread open and loads its remaining allowance with the independence count presented for it, taken from bits [3*t+2 : 3*t] of the count bus.
- R6: A grant to an open thread with a non-zero allowance reduces that allowance by one; an open thread with zero allowance is not granted.
- R7: With a count of 0 a thread has one instruction in flight, so with a completion arriving 21 cycles after each issue it is granted exactly once every 21 cycles.
- R8: A completion tagged with a thread returns it to idle; the thread is eligible in the same cycle the completion is presented, and a grant in that cycle opens a fresh window with the new count.
- R9: A completion tagged with an idle thread leaves every thread's state unchanged.
- R10: No thread is ever granted more instructions after the one that opened its window than that instruction's count allowed, for any completion latency, including the long ones of memory operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| thr_ready | input | NTHREADS | One flag per thread: its next instruction is available |
| thr_indep | input | NTHREADS*LA_W | Independence count of each thread's next instruction, LA_W bits per thread, thread 0 in the low bits |
| done_valid | input | 1 | A completion is presented this cycle |
| done_tid | input | TID_W | Thread that the completion belongs to |
| iss_valid | output | 1 | An instruction is issued this cycle |
| iss_tid | output | TID_W | Thread that issues this cycle |

## Verification
The checker assumes that a completion is only ever presented for a thread that has an open window, and at most one per window, because it models each window as closed by one completion. It also assumes the count bus is stable while the clock edge samples it and the tag on a completion names an existing thread. The stimulus sends each completion only after the thread it names has issued. It uses tags within range, and the single stray completion on an idle thread is aimed at checking that it has no effect. Inputs change only between clock edges, well away from sampling.

// File: rtl/la_issue_pkg.sv
// Package: shared types and helpers for the lookahead-gated issue controller.
// Assumes nothing beyond being compiled before the modules that import it.
package la_issue_pkg;

    // Per-thread window state: idle (no outstanding window opener) or open.
    typedef enum logic {
        SLOT_IDLE = 1'b0,
        SLOT_OPEN = 1'b1
    } slot_mode_e;

    // Wrap an index that has run at most one lap past the thread count.
    function automatic int wrap_index(input int idx, input int count);
        return (idx >= count) ? (idx - count) : idx;
    endfunction

endpackage

// File: rtl/la_thread_slot.sv
// Module: la_thread_slot
// Holds the issue window of one thread. An idle thread that is granted opens a
// window whose allowance is the independence count of the granted instruction;
// each further grant while open spends one unit. A completion closes the window
// and takes effect in the same cycle it is presented, so a simultaneous grant
// opens a fresh window. Assumes at most one completion per open window.
module la_thread_slot
    import la_issue_pkg::*;
#(
    parameter int LA_W = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            done_hit,
    input  logic            grant,
    input  logic [LA_W-1:0] indep,
    output logic            eligible
);

    slot_mode_e      mode_q;
    slot_mode_e      mode_eff;
    logic [LA_W-1:0] credit_q;

    // Purpose: view of the window once this cycle's completion is applied.
    always_comb begin
        mode_eff = done_hit ? SLOT_IDLE : mode_q;
        eligible = (mode_eff == SLOT_IDLE) || (credit_q != '0);
    end

    // Purpose: open, spend or close the window at the clock edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= SLOT_IDLE;
            credit_q <= '0;
        end else if (grant) begin
            mode_q   <= SLOT_OPEN;
            credit_q <= (mode_eff == SLOT_IDLE) ? indep : (credit_q - 1'b1);
        end else if (done_hit) begin
            mode_q   <= SLOT_IDLE;
            credit_q <= '0;
        end
    end

endmodule

// File: rtl/la_rr_pick.sv
// Module: la_rr_pick
// Round-robin selector: finds the first requesting index searching upward from
// one past the last winner, wrapping after the top index. Purely combinational.
// Assumes last_tid names an existing thread.
module la_rr_pick
    import la_issue_pkg::*;
#(
    parameter int NREQ  = 16,
    parameter int TID_W = 4
) (
    input  logic [NREQ-1:0]  req,
    input  logic [TID_W-1:0] last_tid,
    output logic             gnt_valid,
    output logic [TID_W-1:0] gnt_tid
);

    // Purpose: rotating first-one search over the request vector.
    always_comb begin
        int idx;
        gnt_valid = 1'b0;
        gnt_tid   = last_tid;
        for (int i = 1; i <= NREQ; i++) begin
            idx = wrap_index(int'(last_tid) + i, NREQ);
            if (!gnt_valid && req[idx]) begin
                gnt_valid = 1'b1;
                gnt_tid   = TID_W'(idx);
            end
        end
    end

endmodule

// File: rtl/la_issue_ctrl.sv
// Module: la_issue_ctrl (top)
// Grants one thread per cycle into a deep pipeline. A thread is eligible when
// its ready flag is set and its issue window is idle or still has allowance.
// Rotation resumes after the most recent grant. The grant is combinational on
// the current inputs and is taken as the issue at the next clock edge.
// Assumes completions name existing threads, at most one per cycle.
module la_issue_ctrl #(
    parameter  int NTHREADS = 16,
    parameter  int LA_W     = 3,
    localparam int TID_W    = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NTHREADS-1:0]      thr_ready,
    input  logic [NTHREADS*LA_W-1:0] thr_indep,
    input  logic                     done_valid,
    input  logic [TID_W-1:0]         done_tid,
    output logic                     iss_valid,
    output logic [TID_W-1:0]         iss_tid
);

    logic [NTHREADS-1:0] done_hit;
    logic [NTHREADS-1:0] slot_ok;
    logic [NTHREADS-1:0] grant_vec;
    logic [NTHREADS-1:0] request;
    logic [TID_W-1:0]    last_q;

    for (genvar t = 0; t < NTHREADS; t++) begin : g_slot
        // Purpose: decode completion tag and grant for this thread.
        always_comb begin
            done_hit[t]  = done_valid && (done_tid == TID_W'(t));
            grant_vec[t] = iss_valid && (iss_tid == TID_W'(t));
        end

        la_thread_slot #(
            .LA_W(LA_W)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .done_hit (done_hit[t]),
            .grant    (grant_vec[t]),
            .indep    (thr_indep[t*LA_W +: LA_W]),
            .eligible (slot_ok[t])
        );
    end

    // Purpose: a thread requests when it has an instruction and may issue.
    always_comb request = thr_ready & slot_ok;

    la_rr_pick #(
        .NREQ (NTHREADS),
        .TID_W(TID_W)
    ) u_pick (
        .req      (request),
        .last_tid (last_q),
        .gnt_valid(iss_valid),
        .gnt_tid  (iss_tid)
    );

    // Purpose: remember the last granted thread; reset so thread 0 is first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= TID_W'(NTHREADS - 1);
        end else if (iss_valid) begin
            last_q <= iss_tid;
        end
    end

endmodule

// File: rtl/la_issue_ctrl_chk.sv
// Module: la_issue_ctrl_chk
// Observes the controller's ports and keeps its own record of each thread's
// window (opened by an idle grant, closed by a completion) to check grant
// legality, work conservation and that no window is overrun.
// Assumes one completion per open window.
module la_issue_ctrl_chk #(
    parameter  int NTHREADS = 16,
    parameter  int LA_W     = 3,
    localparam int TID_W    = (NTHREADS > 1) ? $clog2(NTHREADS) : 1
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NTHREADS-1:0]      thr_ready,
    input logic [NTHREADS*LA_W-1:0] thr_indep,
    input logic                     done_valid,
    input logic [TID_W-1:0]         done_tid,
    input logic                     iss_valid,
    input logic [TID_W-1:0]         iss_tid
);

    logic [NTHREADS-1:0] open_q;
    logic [NTHREADS-1:0] idle_now;

    // R2: a grant always names a ready thread.
    p_grant_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> thr_ready[iss_tid]);

    // R3: a ready thread with no open window is never left waiting.
    p_idle_served_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|(thr_ready & idle_now)) |-> iss_valid);

    for (genvar t = 0; t < NTHREADS; t++) begin : g_thr
        logic [LA_W-1:0] allow_q;
        logic [LA_W-1:0] used_q;
        logic            hit;
        logic            won;

        // Purpose: decode this thread's completion and grant.
        always_comb begin
            hit         = done_valid && (done_tid == TID_W'(t));
            won         = iss_valid && (iss_tid == TID_W'(t));
            idle_now[t] = !open_q[t] || hit;
        end

        // Purpose: independent record of the window opener and issues past it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q[t] <= 1'b0;
                allow_q   <= '0;
                used_q    <= '0;
            end else if (won && idle_now[t]) begin
                open_q[t] <= 1'b1;
                allow_q   <= thr_indep[t*LA_W +: LA_W];
                used_q    <= '0;
            end else if (won) begin
                used_q    <= used_q + 1'b1;
            end else if (hit) begin
                open_q[t] <= 1'b0;
            end
        end

        // R10: issues past the opener stay within its independence count.
        p_no_overrun_r10: assert property (@(posedge clk) disable iff (!rst_n)
            (won && !idle_now[t]) |-> (used_q < allow_q));

        // R6: an exhausted open window blocks the thread.
        p_exhausted_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (open_q[t] && !hit && (used_q == allow_q)) |-> !won);
    end

endmodule

bind la_issue_ctrl la_issue_ctrl_chk #(
    .NTHREADS(NTHREADS),
    .LA_W    (LA_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .thr_ready (thr_ready),
    .thr_indep (thr_indep),
    .done_valid(done_valid),
    .done_tid  (done_tid),
    .iss_valid (iss_valid),
    .iss_tid   (iss_tid)
);

// File: tb/la_issue_ctrl_test.sv
// Bench for la_issue_ctrl: a stepped vector table from reset, then directed
// tests for reset, rotation over all threads, the one-in-flight rate and a
// long-latency completion.
module la_issue_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int NT         = 16;
    localparam int LW         = 3;
    localparam int TW         = 4;
    localparam int NVEC       = 17;

    // Vector: {ready[15:0], indep[2:0] (all threads), done_v, done_tid[3:0], exp_v, exp_tid[3:0]}
    localparam logic [28:0] VEC [NVEC] = '{
        {16'h0001, 3'd0, 1'b0, 4'd0, 1'b1, 4'd0},   // 0  R1 R5: first grant thread 0, count 0
        {16'h0001, 3'd0, 1'b0, 4'd0, 1'b0, 4'd0},   // 1  R7: thread 0 blocked
        {16'h0001, 3'd0, 1'b1, 4'd0, 1'b1, 4'd0},   // 2  R8: same-cycle completion re-enables
        {16'h0003, 3'd2, 1'b0, 4'd0, 1'b1, 4'd1},   // 3  R5: thread 1 opens with 2
        {16'h0002, 3'd2, 1'b0, 4'd0, 1'b1, 4'd1},   // 4  R6: spend 1
        {16'h0002, 3'd2, 1'b0, 4'd0, 1'b1, 4'd1},   // 5  R6: spend 2
        {16'h0002, 3'd2, 1'b0, 4'd0, 1'b0, 4'd0},   // 6  R6 R10: exhausted
        {16'h0002, 3'd2, 1'b1, 4'd5, 1'b0, 4'd0},   // 7  R9: stray completion on idle thread 5
        {16'h0006, 3'd7, 1'b0, 4'd0, 1'b1, 4'd2},   // 8  R5: thread 2 opens with 7
        {16'h0007, 3'd7, 1'b1, 4'd1, 1'b1, 4'd1},   // 9  R4 R8: wrap past blocked 0 to 1
        {16'h0007, 3'd7, 1'b0, 4'd0, 1'b1, 4'd2},   // 10 R4
        {16'h0007, 3'd7, 1'b0, 4'd0, 1'b1, 4'd1},   // 11 R4
        {16'h8007, 3'd0, 1'b0, 4'd0, 1'b1, 4'd2},   // 12 R4
        {16'h8007, 3'd0, 1'b0, 4'd0, 1'b1, 4'd15},  // 13 R4 R3: top thread
        {16'h8007, 3'd0, 1'b0, 4'd0, 1'b1, 4'd1},   // 14 R4: wrap to 1, 0 still blocked
        {16'h0000, 3'd0, 1'b1, 4'd0, 1'b0, 4'd0},   // 15 R2 R8: nothing ready, 0 completes
        {16'h0001, 3'd3, 1'b0, 4'd0, 1'b1, 4'd0}    // 16 R8: thread 0 idle again
    };

    logic                 clk = 1'b0;
    logic                 rst_n;
    logic [NT-1:0]        thr_ready;
    logic [NT*LW-1:0]     thr_indep;
    logic                 done_valid;
    logic [TW-1:0]        done_tid;
    logic                 iss_valid;
    logic [TW-1:0]        iss_tid;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    la_issue_ctrl #(.NTHREADS(NT), .LA_W(LW)) uut (
        .clk(clk), .rst_n(rst_n), .thr_ready(thr_ready), .thr_indep(thr_indep),
        .done_valid(done_valid), .done_tid(done_tid),
        .iss_valid(iss_valid), .iss_tid(iss_tid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic drive(input logic [NT-1:0] rdy, input logic [LW-1:0] ind,
                         input logic dv, input logic [TW-1:0] dt);
        thr_ready  = rdy;
        thr_indep  = {NT{ind}};
        done_valid = dv;
        done_tid   = dt;
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1 rst_n = 1'b0;
        drive('0, '0, 1'b0, '0);
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        int cnt;
        int nxt;
        rst_n = 1'b0;
        drive('0, '0, 1'b0, '0);
        do_reset();

        // R1: nothing granted with no ready thread after reset
        @(negedge clk);
        check(iss_valid == 1'b0, "R1 idle after reset", int'(iss_valid), 0);

        // Vector table walk
        for (int v = 0; v < NVEC; v++) begin
            @(posedge clk);
            #1 drive(VEC[v][28:13], VEC[v][12:10], VEC[v][9], VEC[v][8:5]);
            @(negedge clk);
            check(iss_valid == VEC[v][4], $sformatf("R2 vector %0d valid", v),
                  int'(iss_valid), int'(VEC[v][4]));
            if (VEC[v][4])
                check(iss_tid == VEC[v][3:0], $sformatf("R4 vector %0d thread", v),
                      int'(iss_tid), int'(VEC[v][3:0]));
        end

        // R1 R4: full rotation with count 0, then R7 all blocked
        do_reset();
        drive('1, 3'd0, 1'b0, '0);
        for (int i = 0; i < NT; i++) begin
            @(negedge clk);
            check(iss_valid && iss_tid == TW'(i), "R4 rotation order", int'(iss_tid), i);
            @(posedge clk);
            #1;
        end
        @(negedge clk);
        check(iss_valid == 1'b0, "R7 all threads blocked", int'(iss_valid), 0);

        // R7: one in flight, completion 21 cycles after each issue
        do_reset();
        cnt = 0;
        nxt = -1;
        for (int c = 0; c < 105; c++) begin
            drive(16'h0008, 3'd0, (c == nxt), TW'(3));
            @(negedge clk);
            if (iss_valid && iss_tid == TW'(3)) begin
                cnt++;
                nxt = c + 21;
            end
            @(posedge clk);
            #1;
        end
        check(cnt == 5, "R7 issue rate", cnt, 5);

        // R6 R8 R10: count 1 with a 150-cycle completion
        do_reset();
        cnt = 0;
        for (int c = 0; c < 160; c++) begin
            drive(16'h0010, 3'd1, (c == 150), TW'(4));
            @(negedge clk);
            if (iss_valid && iss_tid == TW'(4)) cnt++;
            @(posedge clk);
            #1;
        end
        check(cnt == 4, "R10 long latency window", cnt, 4);

        finish_run();
    end

endmodule